// File: doc/BRIEF.md
# Scintillation Event Frame Processor

This block turns one detector event into one compact event record. An event arrives as a frame of per-channel beats. Each beat comes from one validated channel of an 8x8 photosensor tile and carries the channel index, a charge sample and a calibrated time sample. While the frame streams in, the block removes a per-channel pedestal from each charge. It accumulates the total event energy, the charge-weighted row and column moments, and the charge-weighted time. When the final beat arrives it stops taking input and divides the moments by the energy. This gives a quantised position and an energy-weighted event time.

The quantised position addresses an external crystal map, a synchronous memory with one cycle of read latency. The map returns the crystal number, the layer (front or back) and a per-crystal gain. The gain converts the summed charge into keV. An event whose calibrated energy falls inside an inclusive programmable window leaves as one 96-bit record; any other event is dropped. A raw mode skips all of this and echoes every beat as a raw record. Pedestals are written one channel at a time through a small load port.

Top module: `event_frame_proc`

## Requirements
- R1: After reset, out_valid is 0 and ch_ready is 1.
- R2: Each beat contributes s = charge - pedestal[index] when charge is greater than the pedestal, and 0 otherwise. The event energy E is the sum of s over the frame.
- R3: With row = index[5:3] and column = index[2:0], the position is X = floor(32·Σ(s·column)/E) and Y = floor(32·Σ(s·row)/E), 8 bits each. lut_addr is {Y, X}.
- R4: The event time is floor(Σ(s·time)/E), 16 bits.
- R5: lut_rdata, sampled one cycle after lut_addr is presented, is read as layer = bit 23, crystal = bits 22:16 and gain = bits 15:0. Layer and crystal are copied into the record.
- R6: The calibrated energy is floor(E·gain/1024), clamped to 65535 when larger.
- R7: A record is emitted only when win_lo <= calibrated energy <= win_hi; otherwise nothing is emitted.
- R8: A frame whose E is 0 emits nothing, and the next frame is processed normally.
- R9: An event record has bit 95 = 0, bit 94 = layer, bits 93:87 = crystal, 86:71 = energy, 70:55 = time, 54:47 = X, 46:39 = Y, and zeros below.
- R10: With bypass high, every accepted beat gives a record on the next cycle: bit 95 = 1, bits 94:89 = index, 88:77 = charge, 76:61 = time, and zeros below.
- R11: Outside raw mode, ch_ready is low from the cycle after a frame's last beat until that frame has been emitted or dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | Raw echo mode |
| win_lo | input | 16 | Lower energy bound in keV, inclusive |
| win_hi | input | 16 | Upper energy bound in keV, inclusive |
| bl_we | input | 1 | Pedestal write strobe |
| bl_addr | input | 6 | Pedestal channel index |
| bl_data | input | 12 | Pedestal value |
| ch_valid | input | 1 | Channel beat valid |
| ch_ready | output | 1 | Block accepts a beat |
| ch_last | input | 1 | Final beat of the frame |
| ch_idx | input | 6 | Channel index, row in upper three bits |
| ch_charge | input | 12 | Charge sample |
| ch_time | input | 16 | Calibrated time sample |
| lut_addr | output | 16 | Crystal map address {Y, X} |
| lut_rdata | input | 24 | Crystal map entry, one cycle after address |
| out_valid | output | 1 | Record valid, one cycle |
| out_data | output | 96 | Event or raw record |

## Verification
The bench drives frames whose charges sit below the pedestal. A design that fails to clamp would underflow and emit a large bogus energy. The same frames make E zero, where a missing guard would divide by zero and emit garbage. The window is set exactly at one event's energy and then one step past it, on each bound, which exposes off-by-one comparisons. A full 64-channel frame at maximum charge forces the energy clamp, so an unclamped design shows wrapped low bits. Random frames with repeated channels and mixed pedestals expose wrong row/column decoding, a wrong quotient scale and misplaced record fields. The raw-mode beats show whether any beat is lost or reformatted.

// File: rtl/efp_pkg.sv
package efp_pkg;
    localparam int CH_W     = 12;
    localparam int T_W      = 16;
    localparam int AX_BITS  = 3;
    localparam int POS_FRAC = 5;
    localparam int GAIN_W   = 16;
    localparam int XTAL_W   = 7;
    localparam int IDX_W    = 2 * AX_BITS;
    localparam int POS_W    = AX_BITS + POS_FRAC;
    localparam int LUT_W    = XTAL_W + 1 + GAIN_W;
    localparam int PKT_W    = 96;
    localparam int E_W      = 16;

    typedef struct packed {
        logic              layer;
        logic [XTAL_W-1:0] xtal;
        logic [GAIN_W-1:0] gain;
    } map_ent_t;

    typedef enum logic [2:0] {S_ACC, S_CHK, S_DIV, S_LUT, S_EMIT} fsm_t;

    function automatic logic [CH_W-1:0] net_charge(logic [CH_W-1:0] q, logic [CH_W-1:0] ped);
        return (q > ped) ? q - ped : '0;
    endfunction

    function automatic logic [PKT_W-1:0] event_rec(map_ent_t m, logic [E_W-1:0] kev,
                                                  logic [T_W-1:0] t, logic [POS_W-1:0] x,
                                                  logic [POS_W-1:0] y);
        return {1'b0, m.layer, m.xtal, kev, t, x, y, 39'd0};
    endfunction

    function automatic logic [PKT_W-1:0] raw_rec(logic [IDX_W-1:0] idx, logic [CH_W-1:0] q,
                                                logic [T_W-1:0] t);
        return {1'b1, idx, q, t, 61'd0};
    endfunction
endpackage

// File: rtl/efp_div.sv
module efp_div #(
    parameter int N = 34,
    parameter int D = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] num,
    input  logic [D-1:0] den,
    output logic [N-1:0] quo,
    output logic         done
);
    localparam int CW = $clog2(N + 1);

    logic [D:0]    rem;
    logic [N-1:0]  q;
    logic [D-1:0]  dv;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [D:0]    sh;

    assign sh  = {rem[D-1:0], q[N-1]};
    assign quo = q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            q    <= '0;
            dv   <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem  <= '0;
                q    <= num;
                dv   <= den;
                cnt  <= CW'(N);
                busy <= 1'b1;
            end else if (busy) begin
                if (sh >= {1'b0, dv}) begin
                    rem <= sh - {1'b0, dv};
                    q   <= {q[N-2:0], 1'b1};
                end else begin
                    rem <= sh;
                    q   <= {q[N-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/efp_accum.sv
module efp_accum
    import efp_pkg::*;
#(
    parameter int ESUM_W = CH_W + IDX_W,
    parameter int MOM_W  = ESUM_W + AX_BITS,
    parameter int TSUM_W = ESUM_W + T_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              beat,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CH_W-1:0]   charge,
    input  logic [T_W-1:0]    tval,
    input  logic              ped_we,
    input  logic [IDX_W-1:0]  ped_addr,
    input  logic [CH_W-1:0]   ped_data,
    output logic [ESUM_W-1:0] e_sum,
    output logic [MOM_W-1:0]  col_mom,
    output logic [MOM_W-1:0]  row_mom,
    output logic [TSUM_W-1:0] t_mom
);
    localparam int NCH = 1 << IDX_W;

    logic [CH_W-1:0]    ped [NCH];
    logic [CH_W-1:0]    s;
    logic [AX_BITS-1:0] row, col;

    assign s   = net_charge(charge, ped[idx]);
    assign row = idx[IDX_W-1:AX_BITS];
    assign col = idx[AX_BITS-1:0];

    always_ff @(posedge clk) begin
        if (ped_we) ped[ped_addr] <= ped_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            e_sum   <= '0;
            col_mom <= '0;
            row_mom <= '0;
            t_mom   <= '0;
        end else if (beat) begin
            e_sum   <= e_sum + ESUM_W'(s);
            col_mom <= col_mom + MOM_W'(s) * MOM_W'(col);
            row_mom <= row_mom + MOM_W'(s) * MOM_W'(row);
            t_mom   <= t_mom + TSUM_W'(s) * TSUM_W'(tval);
        end
    end
endmodule

// File: rtl/event_frame_proc.sv
module event_frame_proc
    import efp_pkg::*;
#(
    parameter int GAIN_FRAC = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass,
    input  logic [E_W-1:0]    win_lo,
    input  logic [E_W-1:0]    win_hi,
    input  logic              bl_we,
    input  logic [IDX_W-1:0]  bl_addr,
    input  logic [CH_W-1:0]   bl_data,
    input  logic              ch_valid,
    output logic              ch_ready,
    input  logic              ch_last,
    input  logic [IDX_W-1:0]  ch_idx,
    input  logic [CH_W-1:0]   ch_charge,
    input  logic [T_W-1:0]    ch_time,
    output logic [2*POS_W-1:0] lut_addr,
    input  logic [LUT_W-1:0]  lut_rdata,
    output logic              out_valid,
    output logic [PKT_W-1:0]  out_data
);
    localparam int ESUM_W = CH_W + IDX_W;
    localparam int MOM_W  = ESUM_W + AX_BITS;
    localparam int TSUM_W = ESUM_W + T_W;
    localparam int NUM_W  = (MOM_W + POS_FRAC > TSUM_W) ? MOM_W + POS_FRAC : TSUM_W;
    localparam int PROD_W = ESUM_W + GAIN_W;
    localparam int NDIV   = 3;

    fsm_t              st;
    logic              fire, beat, clr, div_go;
    logic [ESUM_W-1:0] e_sum;
    logic [MOM_W-1:0]  col_mom, row_mom;
    logic [TSUM_W-1:0] t_mom;
    logic [NUM_W-1:0]  nums [NDIV];
    logic [NUM_W-1:0]  quos [NDIV];
    logic [NDIV-1:0]   dones;
    logic [T_W-1:0]    t_evt;
    map_ent_t          ent;
    logic [PROD_W-1:0] kev_full;
    logic [E_W-1:0]    kev;
    logic              in_win;

    assign ch_ready = (st == S_ACC);
    assign fire     = ch_valid && ch_ready;
    assign beat     = fire && !bypass;
    assign clr      = (st == S_EMIT) || (st == S_CHK && e_sum == '0);
    assign div_go   = (st == S_CHK) && (e_sum != '0);

    efp_accum u_acc (
        .clk(clk), .rst(rst), .clr(clr), .beat(beat),
        .idx(ch_idx), .charge(ch_charge), .tval(ch_time),
        .ped_we(bl_we), .ped_addr(bl_addr), .ped_data(bl_data),
        .e_sum(e_sum), .col_mom(col_mom), .row_mom(row_mom), .t_mom(t_mom)
    );

    assign nums[0] = NUM_W'(col_mom) << POS_FRAC;
    assign nums[1] = NUM_W'(row_mom) << POS_FRAC;
    assign nums[2] = NUM_W'(t_mom);

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        efp_div #(.N(NUM_W), .D(ESUM_W)) u_div (
            .clk(clk), .rst(rst), .start(div_go), .num(nums[g]), .den(e_sum),
            .quo(quos[g]), .done(dones[g])
        );
    end

    assign ent      = map_ent_t'(lut_rdata);
    assign kev_full = (PROD_W'(e_sum) * PROD_W'(ent.gain)) >> GAIN_FRAC;
    assign kev      = (kev_full > PROD_W'({E_W{1'b1}})) ? {E_W{1'b1}} : kev_full[E_W-1:0];
    assign in_win   = (kev >= win_lo) && (kev <= win_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_ACC;
            lut_addr  <= '0;
            t_evt     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (st)
                S_ACC: begin
                    if (fire && bypass) begin
                        out_valid <= 1'b1;
                        out_data  <= raw_rec(ch_idx, ch_charge, ch_time);
                    end
                    if (beat && ch_last) st <= S_CHK;
                end
                S_CHK:  st <= (e_sum == '0) ? S_ACC : S_DIV;
                S_DIV: begin
                    if (dones[0]) begin
                        lut_addr <= {quos[1][POS_W-1:0], quos[0][POS_W-1:0]};
                        t_evt    <= quos[2][T_W-1:0];
                        st       <= S_LUT;
                    end
                end
                S_LUT:  st <= S_EMIT;
                S_EMIT: begin
                    out_valid <= in_win;
                    out_data  <= event_rec(ent, kev, t_evt,
                                           lut_addr[POS_W-1:0], lut_addr[2*POS_W-1:POS_W]);
                    st        <= S_ACC;
                end
                default: st <= S_ACC;
            endcase
        end
    end
endmodule

// File: rtl/efp_chk.sv
module efp_chk (
    input logic        clk,
    input logic        rst,
    input logic        bypass,
    input logic [15:0] win_lo,
    input logic [15:0] win_hi,
    input logic        ch_valid,
    input logic        ch_ready,
    input logic        ch_last,
    input logic [15:0] lut_addr,
    input logic        out_valid,
    input logic [95:0] out_data
);
    assert_stall_after_last_R11: assert property (@(posedge clk) disable iff (rst)
        (ch_valid && ch_ready && ch_last && !bypass) |=> !ch_ready);

    assert_idle_at_emit_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_data[95]) |-> ch_ready);

    assert_raw_echo_R10: assert property (@(posedge clk) disable iff (rst)
        (ch_valid && ch_ready && bypass) |=> (out_valid && out_data[95]));

    assert_in_window_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_data[95]) |-> (out_data[86:71] >= win_lo && out_data[86:71] <= win_hi));

    assert_pos_matches_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_data[95]) |-> (lut_addr == {out_data[46:39], out_data[54:47]}));
endmodule

bind event_frame_proc efp_chk u_chk (
    .clk(clk), .rst(rst), .bypass(bypass), .win_lo(win_lo), .win_hi(win_hi),
    .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_last(ch_last),
    .lut_addr(lut_addr), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/event_frame_proc_test.sv
module event_frame_proc_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bypass = 1'b0;
    logic [15:0] win_lo = 16'd0, win_hi = 16'hFFFF;
    logic        bl_we = 1'b0;
    logic [5:0]  bl_addr = '0;
    logic [11:0] bl_data = '0;
    logic        ch_valid = 1'b0, ch_last = 1'b0;
    logic        ch_ready;
    logic [5:0]  ch_idx = '0;
    logic [11:0] ch_charge = '0;
    logic [15:0] ch_time = '0;
    logic [15:0] lut_addr;
    logic [23:0] lut_rdata;
    logic        out_valid;
    logic [95:0] out_data;

    int checks = 0, fails = 0;
    int ped [64];
    int f_idx [64];
    int f_q [64];
    int f_t [64];
    int f_n = 0;
    logic [95:0] got_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    event_frame_proc uut (
        .clk(clk), .rst(rst), .bypass(bypass), .win_lo(win_lo), .win_hi(win_hi),
        .bl_we(bl_we), .bl_addr(bl_addr), .bl_data(bl_data),
        .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_last(ch_last),
        .ch_idx(ch_idx), .ch_charge(ch_charge), .ch_time(ch_time),
        .lut_addr(lut_addr), .lut_rdata(lut_rdata),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [23:0] map_fn(logic [15:0] a);
        logic [15:0] g;
        g = 16'd800 + {8'd0, a[11:8], 4'd0} + {12'd0, a[3:0]};
        return {a[15] ^ a[7], a[15:13], a[7:4], g};
    endfunction

    always_ff @(posedge clk) lut_rdata <= map_fn(lut_addr);

    always @(negedge clk) if (out_valid) got_q.push_back(out_data);

    task automatic check(bit ok, string req, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic calc(output bit has, output logic [95:0] pkt, output longint kev_o);
        longint e = 0, xw = 0, yw = 0, tw = 0, s, x, y, t, kev;
        logic [23:0] m;
        for (int k = 0; k < f_n; k++) begin
            s = (f_q[k] > ped[f_idx[k]]) ? f_q[k] - ped[f_idx[k]] : 0;
            e += s;
            xw += s * (f_idx[k] % 8);
            yw += s * (f_idx[k] / 8);
            tw += s * f_t[k];
        end
        has = 0; pkt = '0; kev_o = 0;
        if (e == 0) return;
        x = (xw * 32) / e;
        y = (yw * 32) / e;
        t = tw / e;
        m = map_fn({y[7:0], x[7:0]});
        kev = (e * longint'(m[15:0])) >> 10;
        if (kev > 65535) kev = 65535;
        kev_o = kev;
        has = (kev >= win_lo) && (kev <= win_hi);
        pkt = {1'b0, m[23], m[22:16], kev[15:0], t[15:0], x[7:0], y[7:0], 39'd0};
    endtask

    task automatic drive_beat(int idx, int q, int t, bit last);
        bit done = 0;
        ch_valid = 1'b1; ch_idx = idx[5:0]; ch_charge = q[11:0]; ch_time = t[15:0]; ch_last = last;
        while (!done) begin
            if (ch_ready) done = 1;
            @(negedge clk);
        end
        ch_valid = 1'b0; ch_last = 1'b0;
    endtask

    task automatic run_frame(string req);
        bit has;
        logic [95:0] exp;
        longint kev;
        calc(has, exp, kev);
        got_q.delete();
        for (int k = 0; k < f_n; k++) drive_beat(f_idx[k], f_q[k], f_t[k], k == f_n - 1);
        check(ch_ready == 1'b0, "R11 ready low after last", {95'd0, ch_ready}, 96'd0);
        for (int w = 0; w < 150 && got_q.size() == 0; w++) @(negedge clk);
        if (has)
            check(got_q.size() == 1 && got_q[0] == exp, req,
                  got_q.size() > 0 ? got_q[0] : 96'd0, exp);
        else
            check(got_q.size() == 0, req, got_q.size() > 0 ? got_q[0] : 96'd0, 96'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary_and_end();
    end

    initial begin
        bit has;
        logic [95:0] exp;
        longint kev;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && ch_ready == 1'b1, "R1 reset state",
              {94'd0, out_valid, ch_ready}, 96'd1);

        for (int i = 0; i < 64; i++) begin
            ped[i] = $urandom_range(0, 63);
            bl_we = 1'b1; bl_addr = i[5:0]; bl_data = ped[i][11:0];
            @(negedge clk);
        end
        bl_we = 1'b0;

        // R2 R3 R4 R5 R6 R9: random frames, mixed windows
        for (int r = 0; r < 50; r++) begin
            if (r % 2 == 0) begin win_lo = 16'd350; win_hi = 16'd650; end
            else begin win_lo = 16'd0; win_hi = 16'hFFFF; end
            f_n = $urandom_range(1, 6);
            for (int k = 0; k < f_n; k++) begin
                f_idx[k] = $urandom_range(0, 63);
                f_q[k]   = (r % 3 == 0) ? $urandom_range(0, 4095) : $urandom_range(0, 300);
                f_t[k]   = $urandom_range(0, 65535);
            end
            run_frame("R2 R3 R4 R5 R9 random frame");
        end

        // R8: zero energy frame then a normal one
        win_lo = 16'd0; win_hi = 16'hFFFF;
        f_n = 3;
        for (int k = 0; k < 3; k++) begin f_idx[k] = 9 * k; f_q[k] = 0; f_t[k] = 1000 + k; end
        run_frame("R8 zero energy dropped");
        f_q[0] = 900; f_q[1] = 400; f_q[2] = 100;
        run_frame("R8 next frame processed");

        // R7: window bounds exact and one step off
        f_n = 4;
        for (int k = 0; k < 4; k++) begin f_idx[k] = 18 + k; f_q[k] = 200 + 50 * k; f_t[k] = 3000 * k; end
        calc(has, exp, kev);
        win_hi = kev[15:0];
        run_frame("R7 upper bound inclusive");
        win_hi = kev[15:0] - 16'd1;
        run_frame("R7 above upper bound dropped");
        win_hi = 16'hFFFF; win_lo = kev[15:0];
        run_frame("R7 lower bound inclusive");
        win_lo = kev[15:0] + 16'd1;
        run_frame("R7 below lower bound dropped");

        // R6: saturation with a full frame
        win_lo = 16'd0; win_hi = 16'hFFFF;
        f_n = 64;
        for (int k = 0; k < 64; k++) begin f_idx[k] = k; f_q[k] = 4095; f_t[k] = 500; end
        calc(has, exp, kev);
        check(kev == 65535, "R6 bench clamp model", {32'd0, kev}, 96'd65535);
        run_frame("R6 energy clamped");

        // R10: raw mode
        bypass = 1'b1;
        got_q.delete();
        for (int k = 0; k < 4; k++) begin
            f_idx[k] = $urandom_range(0, 63); f_q[k] = $urandom_range(0, 4095); f_t[k] = $urandom_range(0, 65535);
            drive_beat(f_idx[k], f_q[k], f_t[k], k == 3);
        end
        repeat (3) @(negedge clk);
        check(got_q.size() == 4, "R10 one record per beat", {64'd0, got_q.size()}, 96'd4);
        for (int k = 0; k < 4 && k < got_q.size(); k++) begin
            exp = {1'b1, f_idx[k][5:0], f_q[k][11:0], f_t[k][15:0], 61'd0};
            check(got_q[k] == exp, "R10 raw record", got_q[k], exp);
        end
        bypass = 1'b0;

        f_n = 2;
        f_idx[0] = 0; f_q[0] = 700; f_t[0] = 10;
        f_idx[1] = 63; f_q[1] = 700; f_t[1] = 20;
        run_frame("R3 R9 frame after raw mode");

        summary_and_end();
    end
endmodule